// File: doc/BRIEF.md
# DisplayPort Fast Link Training Sequencer

This block runs the fast, handshake-free training of an embedded DisplayPort main link. After a start pulse it programs the sink's configuration registers through a byte-wide native AUX request port. It switches the local transmitter's training-pattern select, waits a fixed settling time, and reads back the sink's per-lane status. Voltage swing and pre-emphasis are fixed, so there is no adjustment loop. Each phase is one write burst, one wait and one status check.

There are three phases. The first is clock recovery on pattern 1. The second is equalization on pattern 3, with the scrambler-reset choice written first. The last turns the pattern off and confirms the lanes once more. The block reports a one-cycle done strobe and a pass flag. Lane count, link-rate code and scrambler-reset enable are sampled when the start pulse is accepted. The settling wait is counted in clock cycles, and its length is derived from the clock frequency parameter.

Top module: `dp_fast_train`

## Requirements
- R1: Out of reset the block is idle: busy, done, pass and auxReq are 0, and patSel is 0 (no pattern).
- R2: An accepted start first writes 0x01 to sink address 0x00108. It then writes 0x21 to address 0x00102, and patSel already reads 1 (pattern 1) when that request is issued.
- R3: In the first two phases, after the pattern write, the block writes 0x24 to address 0x00103+i for each active lane i. The writes go in ascending order of i, with i below the lane count.
- R4: After the last lane write of each of the first two phases, the block waits WAIT_CYCLES clocks. It then reads address 0x00202 followed by 0x00203, and forms the 16-bit status as {byte from 0x00203, byte from 0x00202}. The next read request appears WAIT_CYCLES+1 cycles after the response cycle of that last lane write.
- R5: The first phase passes only if bit 4·i of the status is set for every active lane i. The mask is 0xFFFF shifted right by 4·(4−lane count), ANDed with 0x1111. On failure the block ends with pass 0 and issues no further requests.
- R6: The second phase writes 0x01 (reset enabled) or 0x00 to address 0x0010A. It then sets patSel to 3 and writes 0x23 to 0x00102 when the rate code is 0x14, or 0x22 for any other code. patSel never takes the value 2.
- R7: The second phase passes only if (status AND mask) equals (0x7777 AND mask). Every active lane's nibble must therefore be exactly 0x7, and inactive lanes are ignored.
- R8: After a second-phase pass, patSel returns to 0 and 0x00 is written to 0x00102. The status is then read again with no wait, and the R7 test decides the final pass flag.
- R9: An AUX response with auxErr set ends training at once with pass 0 and patSel 0. No request follows it.
- R10: A start with a lane count other than 1, 2 or 4 gives done with pass 0 on the next cycle, and no AUX request is issued.
- R11: done is a one-cycle pulse. pass changes only together with done and holds afterwards. A start that arrives while busy is ignored.
- R12: auxReq is a single-cycle pulse for each request. auxWrite, auxAddr and auxWdata stay unchanged until the response (auxDone) arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin training when idle |
| laneCount | input | 3 | Active lanes: 1, 2 or 4 |
| rateCode | input | 8 | Link-rate code; 0x14 selects the 0x23 pattern write |
| scramRstEn | input | 1 | Scrambler-reset setting written in phase 2 |
| auxReq | output | 1 | One-cycle request strobe |
| auxWrite | output | 1 | 1 = write, 0 = read |
| auxAddr | output | 20 | Sink register address |
| auxWdata | output | 8 | Write byte |
| auxDone | input | 1 | Response strobe for the outstanding request |
| auxErr | input | 1 | Response carries an error (valid with auxDone) |
| auxRdata | input | 8 | Read byte (valid with auxDone) |
| patSel | output | 2 | Local training pattern: 0 none, 1 pattern 1, 3 pattern 3 |
| busy | output | 1 | Training in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Result of the last completed training |

## Verification
The bench goes after lane masking. One case has garbage bits in inactive lanes' nibbles and expects a pass; a design that ignored the lane count would fail it. Another sets the unused fourth bit on an active lane and expects a fail; a design that masked only the three status flags would accept it. The bench measures the exact gap before each status read, which exposes an off-by-one wait counter and a wait wrongly inserted after the pattern-off write. It also injects AUX errors at the first request and mid-sequence, so a sequencer that kept going or left a pattern selected would log extra requests. Rate codes on both sides of 0x14, an invalid lane count and a start during busy round out the directed cases, and random runs cover the rest.

// File: rtl/dpft_pkg.sv
package dpft_pkg;

  localparam int AUX_AW    = 20;
  localparam int MAX_LANES = 4;
  localparam int LANE_IW   = $clog2(MAX_LANES);
  localparam int STAT_W    = 4 * MAX_LANES;

  localparam logic [AUX_AW-1:0] ADDR_CODING  = 20'h00108;
  localparam logic [AUX_AW-1:0] ADDR_PATTERN = 20'h00102;
  localparam logic [AUX_AW-1:0] ADDR_LANE0   = 20'h00103;
  localparam logic [AUX_AW-1:0] ADDR_EDPCFG  = 20'h0010A;
  localparam logic [AUX_AW-1:0] ADDR_STAT01  = 20'h00202;
  localparam logic [AUX_AW-1:0] ADDR_STAT23  = 20'h00203;

  localparam logic [7:0] VAL_8B10B     = 8'h01;
  localparam logic [7:0] VAL_DRIVE     = 8'h24;
  localparam logic [7:0] VAL_PAT1      = 8'h21;
  localparam logic [7:0] VAL_PAT3_FAST = 8'h23;
  localparam logic [7:0] VAL_PAT3_STD  = 8'h22;
  localparam logic [7:0] VAL_PAT_OFF   = 8'h00;
  localparam logic [7:0] RATE_FAST     = 8'h14;
  localparam logic [3:0] NIBBLE_OK     = 4'h7;

  localparam logic [1:0] PSEL_NONE = 2'd0;
  localparam logic [1:0] PSEL_P1   = 2'd1;
  localparam logic [1:0] PSEL_P3   = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CODING, ST_SCRAM, ST_PATTERN, ST_LANESET,
    ST_WAIT, ST_RDLO, ST_RDHI, ST_CHECK
  } stateT;

  typedef enum logic [1:0] {PH_CR, PH_EQ, PH_OFF} phaseT;

  typedef struct packed {
    logic cfgLoad;
    logic laneClr;
    logic laneInc;
    logic waitClr;
    logic waitRun;
    logic capLo;
    logic capHi;
  } strobeT;

endpackage

// File: rtl/dpft_dpath.sv
module dpft_dpath
  import dpft_pkg::*;
#(
  parameter int WAIT_CYCLES = 52000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  stateT             state,
  input  phaseT             phase,
  input  logic [2:0]        laneCountIn,
  input  logic [7:0]        rateCodeIn,
  input  logic              scramEnIn,
  input  logic [7:0]        auxRdata,
  output logic              cfgValid,
  output logic              laneLast,
  output logic              waitDone,
  output logic              crOk,
  output logic              fullOk,
  output logic              auxWrite,
  output logic [AUX_AW-1:0] auxAddr,
  output logic [7:0]        auxWdata
);

  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [2:0]         laneCnt;
  logic [7:0]         rateCode;
  logic               scramEn;
  logic [LANE_IW-1:0] laneIdx;
  logic [CNT_W-1:0]   waitCnt;
  logic [7:0]         statLo;
  logic [7:0]         statHi;
  logic [STAT_W-1:0]  status;
  logic [MAX_LANES-1:0] laneOn;
  logic [MAX_LANES-1:0] laneCr;
  logic [MAX_LANES-1:0] laneFull;
  logic [7:0]         patVal;

  assign cfgValid = (laneCountIn == 3'd1) || (laneCountIn == 3'd2) ||
                    (laneCountIn == 3'd4);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      laneCnt  <= 3'd0;
      rateCode <= 8'd0;
      scramEn  <= 1'b0;
      laneIdx  <= '0;
      waitCnt  <= '0;
      statLo   <= 8'd0;
      statHi   <= 8'd0;
    end else begin
      if (stb.cfgLoad) begin
        laneCnt  <= laneCountIn;
        rateCode <= rateCodeIn;
        scramEn  <= scramEnIn;
      end
      if (stb.laneClr)      laneIdx <= '0;
      else if (stb.laneInc) laneIdx <= laneIdx + 1'b1;
      if (stb.waitClr)      waitCnt <= '0;
      else if (stb.waitRun) waitCnt <= waitCnt + 1'b1;
      if (stb.capLo) statLo <= auxRdata;
      if (stb.capHi) statHi <= auxRdata;
    end
  end

  assign laneLast = (3'(laneIdx) == (laneCnt - 3'd1));
  assign waitDone = (waitCnt == CNT_LAST);
  assign status   = {statHi, statLo};

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_lane
    assign laneOn[g]   = (3'(g) < laneCnt);
    assign laneCr[g]   = !laneOn[g] || status[4*g];
    assign laneFull[g] = !laneOn[g] || (status[4*g+3:4*g] == NIBBLE_OK);
  end

  assign crOk   = &laneCr;
  assign fullOk = &laneFull;

  always_comb begin
    case (phase)
      PH_CR:   patVal = VAL_PAT1;
      PH_EQ:   patVal = (rateCode == RATE_FAST) ? VAL_PAT3_FAST : VAL_PAT3_STD;
      default: patVal = VAL_PAT_OFF;
    endcase
  end

  always_comb begin
    auxWrite = 1'b1;
    auxAddr  = ADDR_CODING;
    auxWdata = 8'h00;
    case (state)
      ST_CODING:  begin auxAddr = ADDR_CODING;  auxWdata = VAL_8B10B; end
      ST_SCRAM:   begin auxAddr = ADDR_EDPCFG;  auxWdata = {7'd0, scramEn}; end
      ST_PATTERN: begin auxAddr = ADDR_PATTERN; auxWdata = patVal; end
      ST_LANESET: begin
        auxAddr  = ADDR_LANE0 + AUX_AW'(laneIdx);
        auxWdata = VAL_DRIVE;
      end
      ST_RDLO:    begin auxAddr = ADDR_STAT01; auxWrite = 1'b0; end
      ST_RDHI:    begin auxAddr = ADDR_STAT23; auxWrite = 1'b0; end
      default:    begin auxAddr = ADDR_CODING; auxWdata = 8'h00; end
    endcase
  end

endmodule

// File: rtl/dpft_ctrl.sv
module dpft_ctrl
  import dpft_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       cfgValid,
  input  logic       auxDone,
  input  logic       auxErr,
  input  logic       laneLast,
  input  logic       waitDone,
  input  logic       crOk,
  input  logic       fullOk,
  output stateT      state,
  output phaseT      phase,
  output strobeT     stb,
  output logic       auxReq,
  output logic [1:0] patSel,
  output logic       busy,
  output logic       done,
  output logic       pass
);

  stateT      stateN;
  phaseT      phaseN;
  logic       waitRsp;
  logic [1:0] patSelN;
  logic       doneN;
  logic       passN;
  logic       isAux;
  logic       rspOk;
  logic       rspBad;

  assign isAux = (state == ST_CODING) || (state == ST_SCRAM) ||
                 (state == ST_PATTERN) || (state == ST_LANESET) ||
                 (state == ST_RDLO) || (state == ST_RDHI);
  assign auxReq = isAux && !waitRsp;
  assign rspOk  = isAux && waitRsp && auxDone && !auxErr;
  assign rspBad = isAux && waitRsp && auxDone && auxErr;
  assign busy   = (state != ST_IDLE);

  always_comb begin
    stateN  = state;
    phaseN  = phase;
    patSelN = patSel;
    doneN   = 1'b0;
    passN   = pass;
    stb     = '0;
    stb.waitRun = (state == ST_WAIT);
    if (rspBad) begin
      stateN  = ST_IDLE;
      doneN   = 1'b1;
      passN   = 1'b0;
      patSelN = PSEL_NONE;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          if (cfgValid) begin
            stateN      = ST_CODING;
            stb.cfgLoad = 1'b1;
          end else begin
            doneN = 1'b1;
            passN = 1'b0;
          end
        end
        ST_CODING: if (rspOk) begin
          stateN  = ST_PATTERN;
          phaseN  = PH_CR;
          patSelN = PSEL_P1;
        end
        ST_SCRAM: if (rspOk) begin
          stateN  = ST_PATTERN;
          patSelN = PSEL_P3;
        end
        ST_PATTERN: if (rspOk) begin
          if (phase == PH_OFF) begin
            stateN = ST_RDLO;
          end else begin
            stateN      = ST_LANESET;
            stb.laneClr = 1'b1;
          end
        end
        ST_LANESET: if (rspOk) begin
          if (laneLast) begin
            stateN      = ST_WAIT;
            stb.waitClr = 1'b1;
          end else begin
            stb.laneInc = 1'b1;
          end
        end
        ST_WAIT: if (waitDone) stateN = ST_RDLO;
        ST_RDLO: if (rspOk) begin
          stateN    = ST_RDHI;
          stb.capLo = 1'b1;
        end
        ST_RDHI: if (rspOk) begin
          stateN    = ST_CHECK;
          stb.capHi = 1'b1;
        end
        ST_CHECK: begin
          case (phase)
            PH_CR: if (crOk) begin
              stateN = ST_SCRAM;
              phaseN = PH_EQ;
            end
            PH_EQ: if (fullOk) begin
              stateN  = ST_PATTERN;
              phaseN  = PH_OFF;
              patSelN = PSEL_NONE;
            end
            default: ;
          endcase
          if ((phase == PH_OFF) ||
              ((phase == PH_CR) && !crOk) ||
              ((phase == PH_EQ) && !fullOk)) begin
            stateN  = ST_IDLE;
            doneN   = 1'b1;
            passN   = (phase == PH_OFF) && fullOk;
            patSelN = PSEL_NONE;
          end
        end
        default: stateN = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      phase   <= PH_CR;
      waitRsp <= 1'b0;
      patSel  <= PSEL_NONE;
      done    <= 1'b0;
      pass    <= 1'b0;
    end else begin
      state  <= stateN;
      phase  <= phaseN;
      patSel <= patSelN;
      done   <= doneN;
      pass   <= passN;
      if (auxReq)                         waitRsp <= 1'b1;
      else if (isAux && waitRsp && auxDone) waitRsp <= 1'b0;
    end
  end

endmodule

// File: rtl/dp_fast_train.sv
module dp_fast_train
  import dpft_pkg::*;
#(
  parameter int CLK_HZ  = 100_000_000,
  parameter int WAIT_US = 520
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        laneCount,
  input  logic [7:0]        rateCode,
  input  logic              scramRstEn,
  output logic              auxReq,
  output logic              auxWrite,
  output logic [AUX_AW-1:0] auxAddr,
  output logic [7:0]        auxWdata,
  input  logic              auxDone,
  input  logic              auxErr,
  input  logic [7:0]        auxRdata,
  output logic [1:0]        patSel,
  output logic              busy,
  output logic              done,
  output logic              pass
);

  localparam int WAIT_RAW    = ((CLK_HZ / 1000) * WAIT_US) / 1000;
  localparam int WAIT_CYCLES = (WAIT_RAW < 1) ? 1 : WAIT_RAW;

  stateT  state;
  phaseT  phase;
  strobeT stb;
  logic   cfgValid;
  logic   laneLast;
  logic   waitDone;
  logic   crOk;
  logic   fullOk;

  dpft_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgValid (cfgValid),
    .auxDone  (auxDone),
    .auxErr   (auxErr),
    .laneLast (laneLast),
    .waitDone (waitDone),
    .crOk     (crOk),
    .fullOk   (fullOk),
    .state    (state),
    .phase    (phase),
    .stb      (stb),
    .auxReq   (auxReq),
    .patSel   (patSel),
    .busy     (busy),
    .done     (done),
    .pass     (pass)
  );

  dpft_dpath #(.WAIT_CYCLES(WAIT_CYCLES)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .state       (state),
    .phase       (phase),
    .laneCountIn (laneCount),
    .rateCodeIn  (rateCode),
    .scramEnIn   (scramRstEn),
    .auxRdata    (auxRdata),
    .cfgValid    (cfgValid),
    .laneLast    (laneLast),
    .waitDone    (waitDone),
    .crOk        (crOk),
    .fullOk      (fullOk),
    .auxWrite    (auxWrite),
    .auxAddr     (auxAddr),
    .auxWdata    (auxWdata)
  );

endmodule

// File: rtl/dpft_checks.sv
module dpft_checks (
  input logic       clk,
  input logic       rstN,
  input logic       auxReq,
  input logic [1:0] patSel,
  input logic       busy,
  input logic       done,
  input logic       pass
);

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    auxReq |=> !auxReq); // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R11

  AST_PASS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(pass)); // R11

  AST_IDLE_NO_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (patSel == 2'd0)); // R9

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !auxReq); // R9

  AST_PAT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    patSel != 2'd2); // R6

endmodule

bind dp_fast_train dpft_checks u_checks (
  .clk    (clk),
  .rstN   (rstN),
  .auxReq (auxReq),
  .patSel (patSel),
  .busy   (busy),
  .done   (done),
  .pass   (pass)
);

// File: tb/dp_fast_train_bench.sv
module dp_fast_train_bench;

  localparam int BENCH_HZ = 100_000;
  localparam int W        = ((BENCH_HZ / 1000) * 520) / 1000;
  localparam int NO_ERR   = 999;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  laneCount = 3'd4;
  logic [7:0]  rateCode = 8'h0A;
  logic        scramRstEn = 1'b0;
  logic        auxDone = 1'b0;
  logic        auxErr = 1'b0;
  logic [7:0]  auxRdata = 8'h00;
  logic        auxReq;
  logic        auxWrite;
  logic [19:0] auxAddr;
  logic [7:0]  auxWdata;
  logic [1:0]  patSel;
  logic        busy;
  logic        done;
  logic        pass;

  dp_fast_train #(.CLK_HZ(BENCH_HZ), .WAIT_US(520)) u_dp_fast_train (
    .clk(clk), .rstN(rstN), .start(start), .laneCount(laneCount),
    .rateCode(rateCode), .scramRstEn(scramRstEn), .auxReq(auxReq),
    .auxWrite(auxWrite), .auxAddr(auxAddr), .auxWdata(auxWdata),
    .auxDone(auxDone), .auxErr(auxErr), .auxRdata(auxRdata),
    .patSel(patSel), .busy(busy), .done(done), .pass(pass)
  );

  always #5 clk = ~clk;

  int nChecks = 0;
  int nFail   = 0;

  logic [28:0] logOp [64];
  logic [1:0]  logPat [64];
  int          logReq [64];
  int          logRsp [64];
  int          logCnt = 0;
  int          errAt = NO_ERR;
  int          pairIdx = 0;
  int          strayCnt = 0;
  logic [15:0] stCr = 16'h0, stEq = 16'h0, stOff = 16'h0;

  logic [28:0] expOp [64];
  int          expCnt;
  bit          expPass;
  bit          stopExp;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] laneMask(input int n);
    return 16'hFFFF >> (4 * (4 - n));
  endfunction

  function automatic bit crPass(input logic [15:0] st, input int n);
    logic [15:0] m = laneMask(n) & 16'h1111;
    return (st & m) == m;
  endfunction

  function automatic bit eqPass(input logic [15:0] st, input int n);
    return (st & laneMask(n)) == (16'h7777 & laneMask(n));
  endfunction

  task automatic push(input bit w, input logic [19:0] a, input logic [7:0] d);
    if (stopExp) return;
    expOp[expCnt] = {w, a, w ? d : 8'h00};
    if (expCnt == errAt) stopExp = 1;
    expCnt++;
  endtask

  task automatic buildExp(input int n, input logic [7:0] rate, input bit scr);
    expCnt = 0; expPass = 0; stopExp = 0;
    if (!(n == 1 || n == 2 || n == 4)) return;
    push(1, 20'h00108, 8'h01);
    push(1, 20'h00102, 8'h21);
    for (int i = 0; i < n; i++) push(1, 20'h00103 + 20'(i), 8'h24);
    push(0, 20'h00202, 8'h00);
    push(0, 20'h00203, 8'h00);
    if (stopExp || !crPass(stCr, n)) return;
    push(1, 20'h0010A, {7'd0, scr});
    push(1, 20'h00102, (rate == 8'h14) ? 8'h23 : 8'h22);
    for (int i = 0; i < n; i++) push(1, 20'h00103 + 20'(i), 8'h24);
    push(0, 20'h00202, 8'h00);
    push(0, 20'h00203, 8'h00);
    if (stopExp || !eqPass(stEq, n)) return;
    push(1, 20'h00102, 8'h00);
    push(0, 20'h00202, 8'h00);
    push(0, 20'h00203, 8'h00);
    if (stopExp) return;
    expPass = eqPass(stOff, n);
  endtask

  task automatic responder;
    logic [15:0] cur;
    logic [28:0] op;
    int idx;
    int lat;
    @(negedge clk);
    forever begin
      if (auxReq) begin
        idx = logCnt;
        op = {auxWrite, auxAddr, auxWrite ? auxWdata : 8'h00};
        if (idx < 64) begin
          logOp[idx]  = op;
          logPat[idx] = patSel;
          logReq[idx] = int'($time / 10);
        end
        lat = 1 + int'($urandom % 4);
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          if (auxReq || ({auxWrite, auxAddr, auxWrite ? auxWdata : 8'h00} != op))
            strayCnt++;
        end
        cur = (pairIdx == 0) ? stCr : (pairIdx == 1) ? stEq : stOff;
        auxRdata = 8'h00;
        if (!op[28] && op[27:8] == 20'h00202) auxRdata = cur[7:0];
        if (!op[28] && op[27:8] == 20'h00203) begin
          auxRdata = cur[15:8];
          pairIdx++;
        end
        auxErr  = (idx == errAt);
        auxDone = 1'b1;
        if (idx < 64) logRsp[idx] = int'($time / 10);
        logCnt++;
        @(negedge clk);
        auxDone = 1'b0;
        auxErr  = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic runCase(input string name, input int n, input logic [7:0] rate,
                         input bit scr, input logic [15:0] cr, input logic [15:0] eq,
                         input logic [15:0] off, input int err, input bit poke);
    int t;
    int firstBad;
    int k;
    int cntAtDone;
    @(negedge clk);
    laneCount = 3'(n); rateCode = rate; scramRstEn = scr;
    stCr = cr; stEq = eq; stOff = off; errAt = err;
    logCnt = 0; pairIdx = 0; strayCnt = 0;
    buildExp(n, rate, scr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (!done && t < 5000) begin
      if (poke && t == 20) start = 1'b1;
      if (poke && t == 21) start = 1'b0;
      @(negedge clk);
      t++;
    end
    chk(done, "R11", {name, " done seen"}, done, 1);
    if (!(n == 1 || n == 2 || n == 4))
      chk(t == 0, "R10", {name, " cycles to done"}, t, 0);
    chk(pass == expPass, "R5 R7 R8 R9", {name, " pass"}, pass, expPass);
    chk(patSel == 2'd0, "R9", {name, " patSel at end"}, patSel, 0);
    chk(busy == 1'b0, "R11", {name, " busy at done"}, busy, 0);
    chk(logCnt == expCnt, "R2 R3 R9 R10", {name, " request count"}, logCnt, expCnt);
    firstBad = -1;
    for (int i = 0; i < logCnt && i < expCnt; i++)
      if (firstBad < 0 && logOp[i] != expOp[i]) firstBad = i;
    if (firstBad >= 0)
      chk(0, "R2 R3 R6 R8", {name, " request content"}, logOp[firstBad], expOp[firstBad]);
    else
      chk(1, "R2 R3 R6 R8", {name, " request content"}, 0, 0);
    chk(strayCnt == 0, "R12", {name, " request pulse/stability"}, strayCnt, 0);
    k = 0;
    for (int i = 0; i < logCnt && i < 64; i++) begin
      if (logOp[i][28] && logOp[i][27:8] == 20'h00102) begin
        logic [1:0] ep;
        ep = (logOp[i][7:0] == 8'h21) ? 2'd1 :
             (logOp[i][7:0] == 8'h00) ? 2'd0 : 2'd3;
        chk(logPat[i] == ep, "R2 R6 R8", {name, " patSel at pattern write"},
            logPat[i], ep);
      end
      if (!logOp[i][28] && logOp[i][27:8] == 20'h00202 && i > 0) begin
        int gap;
        gap = logReq[i] - logRsp[i-1];
        if (k < 2) chk(gap == W + 1, "R4", {name, " settle gap"}, gap, W + 1);
        else       chk(gap == 1, "R8", {name, " no wait after pattern off"}, gap, 1);
        k++;
      end
    end
    cntAtDone = logCnt;
    @(negedge clk);
    chk(done == 1'b0, "R11", {name, " done is one cycle"}, done, 0);
    repeat (8) @(negedge clk);
    chk(logCnt == cntAtDone && !busy, "R11", {name, " quiet after done"},
        logCnt, cntAtDone);
    chk(pass == expPass, "R11", {name, " pass holds"}, pass, expPass);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED));
    fork
      responder();
    join_none
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass && !auxReq && patSel == 2'd0, "R1", "reset state",
        {busy, done, pass, auxReq, patSel}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !pass && !auxReq && patSel == 2'd0, "R1", "after reset",
        {busy, done, pass, auxReq, patSel}, 0);

    runCase("four lanes fast rate", 4, 8'h14, 1, 16'h1111, 16'h7777, 16'h7777, NO_ERR, 0);
    runCase("one lane std rate", 1, 8'h0A, 0, 16'h0001, 16'h0007, 16'h0007, NO_ERR, 0);
    runCase("two lanes garbage upper", 2, 8'h06, 1, 16'hF011, 16'h8F77, 16'hFF77, NO_ERR, 0);
    runCase("cr fail lane1", 2, 8'h14, 0, 16'h1101, 16'h7777, 16'h7777, NO_ERR, 0);
    runCase("eq fail lane3 lock", 4, 8'h14, 0, 16'h1111, 16'h3777, 16'h7777, NO_ERR, 0);
    runCase("eq fail bit3 active", 1, 8'h14, 0, 16'h0001, 16'h000F, 16'h0007, NO_ERR, 0);
    runCase("final check fail", 4, 8'h0A, 1, 16'h1111, 16'h7777, 16'h7767, NO_ERR, 0);
    runCase("aux err first", 4, 8'h14, 1, 16'h1111, 16'h7777, 16'h7777, 0, 0);
    runCase("aux err mid", 2, 8'h14, 1, 16'h1111, 16'h7777, 16'h7777, 7, 0);
    runCase("aux err last read", 1, 8'h0A, 0, 16'h0001, 16'h0007, 16'h0007, 12, 0);
    runCase("lane count 3", 3, 8'h14, 0, 16'h1111, 16'h7777, 16'h7777, NO_ERR, 0);
    runCase("lane count 0", 0, 8'h14, 0, 16'h1111, 16'h7777, 16'h7777, NO_ERR, 0);
    runCase("start while busy", 4, 8'h13, 0, 16'h1111, 16'h7777, 16'h7777, NO_ERR, 1);

    for (int r = 0; r < 20; r++) begin
      int n;
      logic [7:0] rate;
      logic [15:0] a, b, c;
      int e;
      n = (($urandom % 3) == 0) ? 1 : ((($urandom % 2) == 0) ? 2 : 4);
      case ($urandom % 4)
        0: rate = 8'h06;
        1: rate = 8'h0A;
        2: rate = 8'h14;
        default: rate = 8'($urandom);
      endcase
      a = 16'h7777; b = 16'h7777; c = 16'h7777;
      if ($urandom % 4 == 0) a = a & ~(16'h1 << ($urandom % 16));
      if ($urandom % 4 == 0) b = b ^ (16'h1 << ($urandom % 16));
      if ($urandom % 5 == 0) c = c & ~(16'h1 << ($urandom % 16));
      e = ($urandom % 4 == 0) ? int'($urandom % 20) : NO_ERR;
      runCase($sformatf("random %0d", r), n, rate, 1'($urandom), a, b, c, e, 0);
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule